// File: doc/BRIEF.md
# Request-Gated Serial Byte Transmitter

This block takes bytes from a buffer through a valid/ready handshake and shifts them out to an external host. The link has three wires: a host request input, a transfer clock output and a data output. An active-high enable output frames every burst. Nothing leaves the port until software has issued a start command, and the host's request line gates every byte after that.

The transfer clock is the master clock divided by 4, 8 or 16. The lead-in time, the pause between bytes and the tail time are each one byte time long, so they scale with the selected rate. Bits go out most significant first. Data changes together with a falling clock edge, and the host samples on the rising edge. When the host drops its request in the middle of a byte, the port finishes that byte and then stops at the byte boundary. When the source is empty, the port sits idle with the clock high.

Top module: `req_serial_tx`

## Requirements
- R1: Until a one-cycle `start_cmd` pulse has armed the port, the port ignores `host_req` and `src_valid`: `ser_en` stays 0, `ser_clk` stays 1 and no byte is taken. The armed state lasts until reset.
- R2: Each byte goes out MSB first. `ser_dat` changes only in the cycle in which `ser_clk` falls, or when `ser_en` changes. The host samples on rising edges.
- R3: The rate encoding is `rate_sel` 0 = divide by 4, 1 = divide by 8, 2 or 3 = divide by 16 (the divider D). Each clock phase is D/2 master cycles low followed by D/2 high. The rate is captured each time a byte is taken.
- R4: `ser_en` rises 8·D master cycles before the first falling edge of `ser_clk` in a burst.
- R5: Between consecutive bytes of a burst, 8·D + D/2 master cycles pass from the last rising edge of one byte to the first falling edge of the next.
- R6: `ser_en` falls 8·D + D/2 master cycles after the last rising edge of a burst. While `ser_en` is 0, `ser_clk` is 1 and `ser_dat` is 0.
- R7: If `host_req` falls during a byte, that byte completes and no further byte is taken. Transfer resumes once `host_req` returns high.
- R8: `src_ready` is high only when the port is armed, `host_req` and `src_valid` are both high, and the port is at a byte boundary. Exactly one byte is taken per handshake. With no byte available, the port stays idle.
- R9: During reset, `ser_en` = 0, `ser_clk` = 1, `ser_dat` = 0 and `src_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_cmd | input | 1 | One-cycle pulse that arms the port |
| rate_sel | input | 2 | Transfer clock rate select |
| host_req | input | 1 | Host request, active high |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Byte taken this cycle |
| ser_clk | output | 1 | Transfer clock, idles high |
| ser_en | output | 1 | Output-valid enable flag |
| ser_dat | output | 1 | Serial data, MSB first |

## Verification
Faults in the phase counter or in the rate capture show up at the first clock phase of a burst, as a low or high phase whose length is not D/2. Lead, pause and tail faults show up within one byte time, as a wrong interval measured from an enable edge or from a rising edge. A broken shift register or bit counter corrupts the byte reconstructed at the eighth rising edge. A faulty arm latch or request gate makes the enable flag rise, or a byte get taken, during a window in which the port should stay silent.

// File: rtl/rstx_pkg.sv
`timescale 1ns/1ps
package rstx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } rstx_state_e;

  localparam int unsigned RATE_W  = 2;
  localparam int unsigned N_SLOTS = 1 << RATE_W;
  localparam int unsigned TOP_SH  = 2;
endpackage

// File: rtl/rstx_rate.sv
`timescale 1ns/1ps
module rstx_rate
  import rstx_pkg::*;
#(
  parameter int unsigned DIV_MIN  = 4,
  parameter int unsigned GAP_BITS = 8,
  parameter int unsigned CNT_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RATE_W-1:0] rate_sel,
  output logic [CNT_W-1:0]  bit_last,
  output logic [CNT_W-1:0]  half_len,
  output logic [CNT_W-1:0]  gap_last
);
  logic [RATE_W-1:0] sel_q;
  logic [RATE_W-1:0] sel_eff;
  logic [CNT_W-1:0]  bit_tab  [N_SLOTS];
  logic [CNT_W-1:0]  half_tab [N_SLOTS];
  logic [CNT_W-1:0]  gap_tab  [N_SLOTS];

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    localparam int unsigned SH  = (g > TOP_SH) ? TOP_SH : g;
    localparam int unsigned DIV = DIV_MIN << SH;
    assign bit_tab[g]  = CNT_W'(DIV - 1);
    assign half_tab[g] = CNT_W'(DIV / 2);
    assign gap_tab[g]  = CNT_W'(GAP_BITS * DIV - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= '0;
    else if (load) sel_q <= rate_sel;
  end

  assign sel_eff  = load ? rate_sel : sel_q;
  assign bit_last = bit_tab[sel_eff];
  assign half_len = half_tab[sel_eff];
  assign gap_last = gap_tab[sel_eff];
endmodule

// File: rtl/rstx_shift.sv
`timescale 1ns/1ps
module rstx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic              msb
);
  logic [DATA_W-1:0] sr_q, sr_n;

  always_comb begin
    sr_n = sr_q;
    if (load)       sr_n = din;
    else if (shift) sr_n = {sr_q[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sr_q <= '0;
    else if (load || shift)  sr_q <= sr_n;
  end

  assign msb = sr_q[DATA_W-1];
endmodule

// File: rtl/rstx_seq.sv
`timescale 1ns/1ps
module rstx_seq
  import rstx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             host_req,
  input  logic             src_valid,
  input  logic [CNT_W-1:0] bit_last,
  input  logic [CNT_W-1:0] half_len,
  input  logic [CNT_W-1:0] gap_last,
  output logic             take,
  output logic             shift,
  output logic             ser_clk,
  output logic             ser_en
);
  localparam int unsigned BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(DATA_W - 1);

  rstx_state_e      st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic             clk_q, clk_n;
  logic             en_q, en_n;
  logic             go;

  assign go = armed && host_req && src_valid;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    bit_n = bit_q;
    take  = 1'b0;
    shift = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go) begin
          take  = 1'b1;
          st_n  = ST_LEAD;
          cnt_n = gap_last;
        end
      end
      ST_LEAD: begin
        if (cnt_q == '0) begin
          st_n  = ST_SHIFT;
          cnt_n = bit_last;
          bit_n = BIT_TOP;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      ST_SHIFT: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - 1'b1;
        end else if (bit_q == '0) begin
          st_n  = ST_GAP;
          cnt_n = gap_last;
        end else begin
          shift = 1'b1;
          bit_n = bit_q - 1'b1;
          cnt_n = bit_last;
        end
      end
      ST_GAP: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - 1'b1;
        end else if (go) begin
          take  = 1'b1;
          st_n  = ST_SHIFT;
          cnt_n = bit_last;
          bit_n = BIT_TOP;
        end else begin
          st_n  = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    en_n  = (st_n != ST_IDLE);
    clk_n = !((st_n == ST_SHIFT) && (cnt_n >= half_len));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      clk_q <= 1'b1;
      en_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      bit_q <= bit_n;
      clk_q <= clk_n;
      en_q  <= en_n;
    end
  end

  assign ser_clk = clk_q;
  assign ser_en  = en_q;
endmodule

// File: rtl/req_serial_tx.sv
`timescale 1ns/1ps
module req_serial_tx
  import rstx_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DIV_MIN  = 4,
  parameter int unsigned GAP_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_cmd,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              host_req,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              ser_clk,
  output logic              ser_en,
  output logic              ser_dat
);
  localparam int unsigned CNT_W = $clog2(GAP_BITS * (DIV_MIN << TOP_SH));

  logic             rs1_q, rs2_q, irst_n;
  logic             arm_q;
  logic             take, shift, msb;
  logic [CNT_W-1:0] bit_last, half_len, gap_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign irst_n = rs2_q;

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n)        arm_q <= 1'b0;
    else if (start_cmd) arm_q <= 1'b1;
  end

  rstx_rate #(.DIV_MIN(DIV_MIN), .GAP_BITS(GAP_BITS), .CNT_W(CNT_W)) u_rate (
    .clk(clk), .rst_n(irst_n), .load(take), .rate_sel(rate_sel),
    .bit_last(bit_last), .half_len(half_len), .gap_last(gap_last)
  );

  rstx_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(irst_n), .armed(arm_q), .host_req(host_req),
    .src_valid(src_valid), .bit_last(bit_last), .half_len(half_len),
    .gap_last(gap_last), .take(take), .shift(shift),
    .ser_clk(ser_clk), .ser_en(ser_en)
  );

  rstx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(irst_n), .load(take), .shift(shift),
    .din(src_data), .msb(msb)
  );

  assign src_ready = take;
  assign ser_dat   = ser_en && msb;
endmodule

// File: rtl/rstx_checker.sv
`timescale 1ns/1ps
module rstx_checker (
  input logic clk,
  input logic rst_n,
  input logic arm_q,
  input logic host_req,
  input logic src_valid,
  input logic src_ready,
  input logic ser_clk,
  input logic ser_en,
  input logic ser_dat
);
  p_quiet_unarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_q |-> (!ser_en && !src_ready));

  p_dat_moves_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && $past(ser_en) && !$fell(ser_clk)) |-> $stable(ser_dat));

  p_fall_inside_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> (ser_en && $past(ser_en)));

  p_idle_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |-> (ser_clk && !ser_dat));

  p_take_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (host_req && src_valid && arm_q));
endmodule

bind req_serial_tx rstx_checker i_rstx_checker (
  .clk(clk), .rst_n(rst_n), .arm_q(arm_q), .host_req(host_req),
  .src_valid(src_valid), .src_ready(src_ready), .ser_clk(ser_clk),
  .ser_en(ser_en), .ser_dat(ser_dat)
);

// File: tb/test_req_serial_tx.sv
`timescale 1ns/1ps
module test_req_serial_tx;
  logic       clk, rst_n, start_cmd, host_req, src_valid, src_ready;
  logic [1:0] rate_sel;
  logic [7:0] src_data;
  logic       ser_clk, ser_en, ser_dat;

  int checks, errors;
  bit done;

  logic [7:0] mem [16];
  int  src_n, src_idx;
  bit  src_on, src_clr;

  int  cur_div, mon_on;
  int  s_en, s_fall, s_rise, nbits, rx_n, en_rises, falls;
  bit  first_bit, p_en, p_clk;
  logic [7:0] sr;
  logic [7:0] rx [16];

  req_serial_tx i_req_serial_tx (
    .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .rate_sel(rate_sel),
    .host_req(host_req), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .ser_clk(ser_clk), .ser_en(ser_en), .ser_dat(ser_dat)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign src_valid = src_on && (src_idx < src_n);
  assign src_data  = mem[src_idx[3:0]];

  always @(posedge clk) begin
    if (src_clr) src_idx <= 0;
    else if (src_valid && src_ready) src_idx <= src_idx + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // receiver model and interval monitor
  always @(negedge clk) begin
    if (mon_on != 0) begin
      s_en++; s_fall++; s_rise++;
      if (ser_en && !p_en) begin s_en = 0; first_bit = 1; en_rises++; end
      if (!ser_clk && p_clk) begin
        falls++;
        if (first_bit)       chk("R4 lead", s_en, 8*cur_div);
        else if (nbits == 0) chk("R5 pause", s_rise, 8*cur_div + cur_div/2);
        else                 chk("R3 high phase", s_rise, cur_div/2);
        first_bit = 0;
        s_fall = 0;
      end
      if (ser_clk && !p_clk) begin
        chk("R3 low phase", s_fall, cur_div/2);
        sr = {sr[6:0], ser_dat};
        nbits++;
        if (nbits == 8) begin rx[rx_n[3:0]] = sr; rx_n++; nbits = 0; end
        s_rise = 0;
      end
      if (!ser_en && p_en) chk("R6 tail", s_rise, 8*cur_div + cur_div/2);
      if (!ser_en && (!ser_clk || ser_dat)) chk("R6 idle lines", {30'd0, ser_clk, ser_dat}, 2);
      p_en = ser_en; p_clk = ser_clk;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wait_done(input int n);
    int t = 0;
    while (!(src_idx == n && !ser_en) && t < 20000) begin tick(1); t++; end
  endtask

  task automatic clear_src(input int n);
    src_n = n; src_clr = 1; tick(1); src_clr = 0; rx_n = 0; nbits = 0;
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 0; start_cmd = 0; host_req = 0; rate_sel = 0; src_on = 0; src_clr = 1;
    src_n = 0; src_idx = 0; mon_on = 0; cur_div = 4;
    s_en = 0; s_fall = 0; s_rise = 0; nbits = 0; rx_n = 0; en_rises = 0; falls = 0;
    first_bit = 0; p_en = 0; p_clk = 1; sr = 0;
    src_on = 1; host_req = 1;
    tick(5);
    // R9 reset state
    chk("R9 en", ser_en, 0);
    chk("R9 clk", ser_clk, 1);
    chk("R9 dat", ser_dat, 0);
    chk("R9 ready", src_ready, 0);
    src_on = 0; host_req = 0;
    rst_n = 1; src_clr = 0;
    tick(4);
    mon_on = 1;

    // R1: requests before arming are ignored
    for (int i = 0; i < 3; i++) mem[i] = 8'(8'h11 * (i + 1));
    clear_src(3);
    src_on = 1; host_req = 1;
    tick(300);
    chk("R1 enable rises", en_rises, 0);
    chk("R1 bytes taken", src_idx, 0);
    host_req = 0;
    tick(2);
    start_cmd = 1; tick(1); start_cmd = 0;

    // R2/R3/R4/R5/R6/R8 sweep over every rate code
    for (int r = 0; r < 4; r++) begin
      rate_sel = 2'(r);
      cur_div  = 4 << ((r > 2) ? 2 : r);
      for (int i = 0; i < 5; i++)
        mem[i] = (i == 0) ? 8'hFF : (i == 1) ? 8'h00 : 8'((r*67 + i*29 + 3) % 256);
      clear_src(5);
      host_req = 1;
      wait_done(5);
      chk("R8 byte count", rx_n, 5);
      for (int i = 0; i < 5; i++) chk("R2 byte value", int'(rx[i]), int'(mem[i]));
      begin
        int er;
        er = en_rises;
        tick(150);
        chk("R8 idle without data", en_rises, er);
        chk("R8 no extra take", src_idx, 5);
      end
      host_req = 0;
      tick(2);
    end

    // R7: request drops inside the first byte
    rate_sel = 0; cur_div = 4;
    mem[0] = 8'h5A; mem[1] = 8'hC3; mem[2] = 8'h3C;
    clear_src(3);
    begin
      int f0, t;
      f0 = falls; t = 0;
      host_req = 1;
      while (falls == f0 && t < 1000) begin tick(1); t++; end
      host_req = 0;
    end
    tick(400);
    chk("R7 one byte finished", rx_n, 1);
    chk("R7 one byte taken", src_idx, 1);
    chk("R7 enable low", ser_en, 0);
    chk("R7 first byte", int'(rx[0]), 8'h5A);
    host_req = 1;
    wait_done(3);
    chk("R7 resumed count", rx_n, 3);
    chk("R7 second byte", int'(rx[1]), 8'hC3);
    chk("R7 third byte", int'(rx[2]), 8'h3C);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule